// File: doc/BRIEF.md
# Eight-Channel Packet Mover

This block moves data between system memory and endpoint buffers of a serial-bus device controller. Software programs each of the eight channels through a 32-bit register window: first a start address and a byte count, then a control word that sets the enable bit. The control word also carries the endpoint, the direction, the request mode, the interrupt enable and the burst size. From then on the channel waits for its endpoint to ask for data. Its transfers go out as word beats on a single memory request/grant port, which the channels share in round-robin order, one burst at a time.

Progress shows live in the registers. The address register advances by the bytes moved. The count register falls by the same amount and reads zero when the job is finished. At that point the enable bit clears itself. If interrupt enable is set, the channel's bit in a shared status byte goes high, and an interrupt line shows that byte ORed together. A memory error on a beat stops the channel, sets a sticky error flag in its control word and raises its status bit. Writing zero to the control word aborts the channel at once.

Each channel has a fixed maximum packet size from an input. In request mode 0, one endpoint strobe lets one packet move. In request mode 1, packets keep moving for as long as the endpoint's request line is high at a packet boundary.

The transfer engine is one state machine with two states. `ST_PICK` chooses the next ready channel by round-robin, after the channel last served. Transition PICK->MOVE happens when any channel is ready. `ST_MOVE` drives the memory request for the chosen channel. Transition MOVE->PICK happens in four cases: the burst reaches its word limit, the packet ends, the beat reports an error, or the channel stops being ready (abort).

Top module: `dmac_top`

## Requirements
- R1: Register window at 0x200, one 16-byte slot per channel n at 0x200+16n. Control sits at slot+0x4 (11 bits, read zero-extended), address at slot+0x8 and count at slot+0xC. A written address reads back with bits 1:0 cleared. The count holds 21 bits, so values up to 0x100000 are kept and higher bits of a write are dropped. All registers reset to 0.
- R2: Control bit fields: bit 0 enable, bit 1 direction (1 = memory to endpoint), bit 2 request mode 1, bit 3 interrupt enable, bits 7:4 endpoint, bit 8 bus-error flag, bits 10:9 burst type. A control write replaces all eleven bits.
- R3: Writing the control word with enable set starts the channel. Each granted beat moves min(4, bytes left in the current packet) bytes: the address rises and the count falls by that amount. While a request waits for its grant, the request and its address stay put.
- R4: When the count reaches 0 the enable bit clears. The channel's status bit is set only if interrupt enable is 1.
- R5: The status byte at 0x200 holds bit n for channel n. Reading it clears it. Writing 1 to a bit clears that bit. A new event in the same cycle wins over the clear. irq_o is the OR of the byte.
- R6: A beat granted with mem_err set moves no data. It sets the bus-error flag, clears enable and raises the channel's status bit whatever the interrupt enable says. The memory request drops on the next cycle.
- R7: Writing 0 to a channel's control word stops it. No further beat is issued for it, and no status bit is raised.
- R8: In mode 0 no data moves until the endpoint's request strobe pulses. Each strobe lets one packet of min(max packet size, count) bytes move.
- R9: In mode 1 a new packet starts whenever the endpoint's request line is high at a packet boundary, until the count reaches 0.
- R10: Burst type 0/1/2/3 allows at most 1/4/8/16 beats per burst. A burst also ends at the end of a packet.
- R11: Channels that are ready at the same time are served in round-robin order, one burst per turn.
- R12: mem_we is 1 for endpoint-to-memory (direction 0) and 0 for memory-to-endpoint. mem_ep carries the served channel's endpoint number.
- R13: Enabling a channel whose count is already 0 finishes it on the next cycle, with the R4 interrupt rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on read) |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while reg_rd is high |
| irq_o | output | 1 | OR of the interrupt status byte |
| ep_req | input | 16 | Per-endpoint request strobe / ready level |
| maxp | input | 88 | Max packet size per channel, 11 bits each, channel 0 lowest |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_we | output | 1 | 1 = beat writes memory |
| mem_ep | output | 4 | Endpoint of the served channel |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | Accepted beat failed |

## Verification
The bound checker watches four properties on every clock. A waiting request and its address stay stable (R3). The request drops right after an error beat (R6). The interrupt line falls only after a status read or write (R5). No burst runs past sixteen beats (R10). Other behaviour can only be shown by the bench's scenarios, checked against its reference model: the exact byte arithmetic across partial packets, the packet gating by strobes versus levels, the round-robin beat order between two channels, the abort sequence, and the interrupt-enable and zero-length rules.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int CTRL_W = 11;
    localparam int EP_W   = 4;

    typedef enum logic [0:0] {
        ST_PICK = 1'b0,
        ST_MOVE = 1'b1
    } eng_state_t;

    // bit 10:9 burst, 8 bus error, 7:4 endpoint, 3 irq enable, 2 mode 1, 1 tx, 0 enable
    typedef struct packed {
        logic [1:0]      burst;
        logic            buserr;
        logic [EP_W-1:0] ep;
        logic            ie;
        logic            mode1;
        logic            tx;
        logic            en;
    } ctrl_t;

    function automatic logic [4:0] burst_words(input logic [1:0] bt);
        logic [4:0] w;
        unique case (bt)
            2'd0:    w = 5'd1;
            2'd1:    w = 5'd4;
            2'd2:    w = 5'd8;
            default: w = 5'd16;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/dmac_rr_pick.sv
module dmac_rr_pick #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = last_i;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last_i) + k) % N;
            if (!any_o && req_i[c]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int CNT_W  = 21,
    parameter int MAXP_W = 11,
    parameter int NEP    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_addr_i,
    input  logic              wr_cnt_i,
    input  logic [31:0]       wdata_i,
    input  logic [NEP-1:0]    ep_req_i,
    input  logic [MAXP_W-1:0] maxp_i,
    input  logic              beat_i,
    input  logic              fault_i,
    output ctrl_t             ctrl_o,
    output logic [31:0]       addr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ready_o,
    output logic              pkt_last_o,
    output logic              done_o,
    output logic              err_o
);

    logic [MAXP_W-1:0] pkt_left;
    logic              pend;
    logic              ep_hit;
    logic              load;
    logic [2:0]        step;
    logic [MAXP_W-1:0] pkt_size;

    assign ep_hit     = ep_req_i[ctrl_o.ep];
    assign step       = (pkt_left < MAXP_W'(4)) ? pkt_left[2:0] : 3'd4;
    assign ready_o    = ctrl_o.en && (pkt_left != '0);
    assign pkt_last_o = (pkt_left <= MAXP_W'(4));
    assign pkt_size   = (cnt_o < CNT_W'(maxp_i)) ? cnt_o[MAXP_W-1:0] : maxp_i;
    assign load       = ctrl_o.en && (cnt_o != '0) && (pkt_left == '0) &&
                        (ctrl_o.mode1 ? ep_hit : pend);
    assign done_o     = (beat_i && (cnt_o == CNT_W'(step))) ||
                        (ctrl_o.en && (cnt_o == '0));
    assign err_o      = fault_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o   <= '0;
            addr_o   <= '0;
            cnt_o    <= '0;
            pkt_left <= '0;
            pend     <= 1'b0;
        end else begin
            pend <= ctrl_o.en && !ctrl_o.mode1 && (ep_hit || (pend && !load));
            if (load) begin
                pkt_left <= pkt_size;
            end
            if (beat_i) begin
                addr_o   <= addr_o + 32'(step);
                cnt_o    <= cnt_o - CNT_W'(step);
                pkt_left <= pkt_left - MAXP_W'(step);
            end
            if (done_o) begin
                ctrl_o.en <= 1'b0;
                pkt_left  <= '0;
            end
            if (fault_i) begin
                ctrl_o.en     <= 1'b0;
                ctrl_o.buserr <= 1'b1;
                pkt_left      <= '0;
            end
            if (wr_addr_i) begin
                addr_o <= {wdata_i[31:2], 2'b00};
            end
            if (wr_cnt_i) begin
                cnt_o <= wdata_i[CNT_W-1:0];
            end
            if (wr_ctrl_i) begin
                ctrl_o   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
                pkt_left <= '0;
                pend     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int CNT_W    = 21,
    parameter int MAXP_W   = 11,
    parameter int NEP      = 16,
    parameter int RA_W     = 12,
    parameter int WIN_BASE = 'h200,
    localparam int IDX_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [RA_W-1:0]       reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  irq_o,
    input  logic [NEP-1:0]        ep_req,
    input  logic [NCH*MAXP_W-1:0] maxp,
    output logic                  mem_req,
    output logic [31:0]           mem_addr,
    output logic                  mem_we,
    output logic [EP_W-1:0]       mem_ep,
    input  logic                  mem_gnt,
    input  logic                  mem_err
);

    localparam logic [RA_W-1:0] WIN_LO = RA_W'(WIN_BASE);
    localparam logic [RA_W-1:0] WIN_HI = RA_W'(WIN_BASE + NCH * 16);

    // register decode
    logic             in_win;
    logic [RA_W-1:0]  rel;
    logic [IDX_W-1:0] slot;
    logic [3:0]       off;
    logic             stat_hit;

    assign in_win   = (reg_addr >= WIN_LO) && (reg_addr < WIN_HI);
    assign rel      = reg_addr - WIN_LO;
    assign slot     = rel[IDX_W+3:4];
    assign off      = rel[3:0];
    assign stat_hit = (reg_addr == WIN_LO);

    // channel state
    ctrl_t            ctrl_q [NCH];
    logic [31:0]      addr_q [NCH];
    logic [CNT_W-1:0] cnt_q  [NCH];
    logic [NCH-1:0]   ready_v, last_v, done_v, err_v, beat_v, fault_v, set_v;

    // engine state
    eng_state_t       state, state_n;
    logic [IDX_W-1:0] cur, last_q;
    logic [4:0]       beats_q;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic             fire;

    logic [NCH-1:0]   irq_st, irq_clr;

    assign fire = mem_req && mem_gnt;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel        = reg_wr && in_win && (slot == IDX_W'(i));
        assign beat_v[i]  = fire && !mem_err && (cur == IDX_W'(i));
        assign fault_v[i] = fire && mem_err && (cur == IDX_W'(i));
        assign set_v[i]   = (done_v[i] && ctrl_q[i].ie) || err_v[i];

        dmac_chan #(
            .CNT_W  (CNT_W),
            .MAXP_W (MAXP_W),
            .NEP    (NEP)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_ctrl_i  (sel && (off == 4'h4)),
            .wr_addr_i  (sel && (off == 4'h8)),
            .wr_cnt_i   (sel && (off == 4'hC)),
            .wdata_i    (reg_wdata),
            .ep_req_i   (ep_req),
            .maxp_i     (maxp[i*MAXP_W +: MAXP_W]),
            .beat_i     (beat_v[i]),
            .fault_i    (fault_v[i]),
            .ctrl_o     (ctrl_q[i]),
            .addr_o     (addr_q[i]),
            .cnt_o      (cnt_q[i]),
            .ready_o    (ready_v[i]),
            .pkt_last_o (last_v[i]),
            .done_o     (done_v[i]),
            .err_o      (err_v[i])
        );
    end

    dmac_rr_pick #(.N(NCH)) u_pick (
        .req_i  (ready_v),
        .last_i (last_q),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_PICK: begin
                if (pick_any) state_n = ST_MOVE;
            end
            ST_MOVE: begin
                if (!ready_v[cur]) begin
                    state_n = ST_PICK;
                end else if (mem_gnt) begin
                    if (mem_err || last_v[cur] ||
                        (beats_q + 5'd1 == burst_words(ctrl_q[cur].burst)))
                        state_n = ST_PICK;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_PICK;
            cur     <= '0;
            last_q  <= '0;
            beats_q <= '0;
        end else begin
            state <= state_n;
            if (state == ST_PICK && pick_any) begin
                cur     <= pick_idx;
                last_q  <= pick_idx;
                beats_q <= '0;
            end else if (fire) begin
                beats_q <= beats_q + 5'd1;
            end
        end
    end

    // engine outputs
    always_comb begin
        mem_req  = (state == ST_MOVE) && ready_v[cur];
        mem_addr = {addr_q[cur][31:2], 2'b00};
        mem_we   = !ctrl_q[cur].tx;
        mem_ep   = ctrl_q[cur].ep;
    end

    // interrupt status
    always_comb begin
        irq_clr = '0;
        if (reg_rd && stat_hit) irq_clr = '1;
        if (reg_wr && stat_hit) irq_clr = irq_clr | reg_wdata[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_st <= '0;
        else        irq_st <= (irq_st & ~irq_clr) | set_v;
    end

    assign irq_o = |irq_st;

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_rd && in_win) begin
            unique case (off)
                4'h0:    reg_rdata = (slot == '0) ? 32'(irq_st) : '0;
                4'h4:    reg_rdata = 32'(ctrl_q[slot]);
                4'h8:    reg_rdata = addr_q[slot];
                4'hC:    reg_rdata = 32'(cnt_q[slot]);
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmac_checker.sv
module dmac_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_rd,
    input logic        reg_wr,
    input logic        irq_o,
    input logic        mem_req,
    input logic        mem_gnt,
    input logic        mem_err,
    input logic [31:0] mem_addr
);

    logic [5:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !mem_req) run_q <= '0;
        else if (mem_gnt && !mem_err && run_q != 6'h3F) run_q <= run_q + 6'd1;
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !reg_wr) |=> (mem_req && $stable(mem_addr)));

    assert_err_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_err) |=> !mem_req);

    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(reg_rd || reg_wr));

    assert_burst_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 6'd16);

endmodule

bind dmac_top dmac_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .irq_o    (irq_o),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_err  (mem_err),
    .mem_addr (mem_addr)
);

// File: tb/dmac_top_bench.sv
module dmac_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    logic [15:0] ep_req = '0;
    logic [87:0] maxp;
    logic        mem_req, mem_we, mem_gnt = 1'b1, mem_err = 1'b0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_ep;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dmac_top u_dmac_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .ep_req(ep_req), .maxp(maxp), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_ep(mem_ep),
        .mem_gnt(mem_gnt), .mem_err(mem_err)
    );

    int mpk [8];
    always_comb begin
        for (int i = 0; i < 8; i++) maxp[i*11 +: 11] = 11'(mpk[i]);
    end

    // behavioural reference model
    logic [31:0] maddr [8];
    int          mcnt [8], mpkt [8], mcred [8];
    bit          men [8], mtx [8], mm1 [8], mie [8], mzl [8];
    int          mep [8];
    logic [7:0]  mirq = '0;
    int          epq [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_rd && reg_addr == 12'h200) mirq = '0;
            if (reg_wr && reg_addr == 12'h200) mirq = mirq & ~reg_wdata[7:0];
            for (int c = 0; c < 8; c++) begin
                if (mzl[c]) begin
                    mzl[c] = 0; men[c] = 0;
                    if (mie[c]) mirq[c] = 1'b1;   // R13
                end
            end
            if (mem_req && mem_gnt) begin
                int c;
                c = (mem_ep == 0) ? 0 : int'(mem_ep) - 1;
                chk(men[c], "R7 beat only for enabled channel", men[c], 1);
                chk(mem_addr == {maddr[c][31:2], 2'b00}, "R3 beat address", mem_addr, maddr[c]);
                chk(mem_we == !mtx[c], "R12 write direction", mem_we, !mtx[c]);
                if (mem_err) begin
                    men[c] = 0; mpkt[c] = 0; mirq[c] = 1'b1;
                end else begin
                    int st;
                    epq.push_back(int'(mem_ep));
                    if (mpkt[c] == 0) begin
                        if (!mm1[c]) begin
                            chk(mcred[c] > 0, "R8 packet needs strobe", mcred[c], 1);
                            if (mcred[c] > 0) mcred[c]--;
                        end
                        mpkt[c] = (mcnt[c] < mpk[c]) ? mcnt[c] : mpk[c];
                    end
                    st = (mpkt[c] < 4) ? mpkt[c] : 4;
                    maddr[c] = maddr[c] + 32'(st);
                    mcnt[c] -= st; mpkt[c] -= st;
                    if (mcnt[c] == 0) begin
                        men[c] = 0;
                        if (mie[c]) mirq[c] = 1'b1;
                    end
                end
            end
            for (int c = 0; c < 8; c++)
                if (men[c] && !mm1[c] && ep_req[mep[c]]) mcred[c]++;
            if (reg_wr && reg_addr >= 12'h200 && reg_addr < 12'h280) begin
                int c;
                c = int'(reg_addr[6:4]);
                case (reg_addr[3:0])
                    4'h4: begin
                        men[c] = reg_wdata[0]; mtx[c] = reg_wdata[1];
                        mm1[c] = reg_wdata[2]; mie[c] = reg_wdata[3];
                        mep[c] = int'(reg_wdata[7:4]); mpkt[c] = 0; mcred[c] = 0;
                        if (reg_wdata[0] && mcnt[c] == 0) mzl[c] = 1;
                    end
                    4'h8: maddr[c] = {reg_wdata[31:2], 2'b00};
                    4'hC: mcnt[c] = int'(reg_wdata[20:0]);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) chk(irq_o == (mirq != 0), "R5 irq line vs model", irq_o, mirq != 0);
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic strobe(input int e);
        @(negedge clk); ep_req[e] = 1;
        @(negedge clk); ep_req[e] = 0;
    endtask

    task automatic wait_done(input int c);
        for (int k = 0; k < 3000 && men[c]; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_req();
        for (int k = 0; k < 50 && !mem_req; k++) @(negedge clk);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            mpk[i] = 64; maddr[i] = '0; mcnt[i] = 0; mpkt[i] = 0; mcred[i] = 0;
            men[i] = 0; mtx[i] = 0; mm1[i] = 0; mie[i] = 0; mzl[i] = 0; mep[i] = 0;
        end
        mpk[1] = 8;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        chk(irq_o == 0, "R5 irq after reset", irq_o, 0);
        chk(mem_req == 0, "R3 no request after reset", mem_req, 0);
        rd_chk(12'h200, 0, "R5 status after reset");
        rd_chk(12'h234, 0, "R1 control after reset");

        // R1/R3/R9/R4: ch0 tx mode 1, 100 bytes, unaligned address
        wr(12'h208, 32'h1003);
        rd_chk(12'h208, 32'h1000, "R1 address low bits cleared");
        wr(12'h20C, 100);
        ep_req[1] = 1;
        wr(12'h204, 32'h61F);
        wait_done(0);
        ep_req[1] = 0;
        rd_chk(12'h20C, 0, "R3 count reaches zero");
        rd_chk(12'h208, 32'h1064, "R3 address advanced by bytes");
        rd_chk(12'h204, 32'h61E, "R4 enable self-clears");
        rd_chk(12'h200, 32'h01, "R4 status bit 0 set");
        rd_chk(12'h200, 32'h00, "R5 clear on read");

        // R8: ch1 rx mode 0, maxp 8, 24 bytes
        wr(12'h218, 32'h2000);
        wr(12'h21C, 24);
        wr(12'h214, 32'h229);
        repeat (10) @(negedge clk);
        rd_chk(12'h21C, 24, "R8 nothing moves before strobe");
        strobe(2);
        repeat (20) @(negedge clk);
        rd_chk(12'h21C, 16, "R8 one packet per strobe");
        strobe(2);
        repeat (20) @(negedge clk);
        strobe(2);
        wait_done(1);
        rd_chk(12'h218, 32'h2018, "R8 receive address");
        rd_chk(12'h214, 32'h228, "R2 control fields kept");
        rd_chk(12'h200, 32'h02, "R4 status bit 1");

        // R11/R10: two channels in round robin, 4-beat bursts
        epq.delete();
        ep_req[3] = 1; ep_req[4] = 1;
        wr(12'h228, 32'h3000); wr(12'h22C, 64);
        wr(12'h238, 32'h4000); wr(12'h23C, 64);
        wr(12'h224, 32'h237);
        wr(12'h234, 32'h247);
        wait_done(2); wait_done(3);
        ep_req[3] = 0; ep_req[4] = 0;
        chk(epq.size() == 32, "R11 beat total", epq.size(), 32);
        if (epq.size() >= 8) begin
            bit ok;
            ok = (epq[0] != epq[4]);
            for (int k = 1; k < 4; k++) ok &= (epq[k] == epq[0]) && (epq[k+4] == epq[4]);
            chk(ok, "R11 alternating 4-beat bursts (R10)", epq[4], epq[0]);
        end
        rd_chk(12'h23C, 0, "R11 second channel finished");
        rd_chk(12'h200, 32'h00, "R4 no status without irq enable");

        // R6: bus error on ch4
        mem_gnt = 0;
        wr(12'h248, 32'h5000); wr(12'h24C, 32);
        ep_req[5] = 1;
        wr(12'h244, 32'h657);
        wait_req();
        mem_gnt = 1; mem_err = 1;
        @(negedge clk); mem_err = 0;
        ep_req[5] = 0;
        repeat (3) @(negedge clk);
        rd_chk(12'h244, 32'h756, "R6 error flag set, enable clear");
        rd_chk(12'h24C, 32, "R6 count unchanged");
        rd_chk(12'h200, 32'h10, "R6 status bit despite irq disabled");

        // R7: abort ch5 while its request waits
        mem_gnt = 0;
        wr(12'h258, 32'h6000); wr(12'h25C, 64);
        ep_req[6] = 1;
        wr(12'h254, 32'h66F);
        wait_req();
        wr(12'h254, 0); wr(12'h258, 0); wr(12'h25C, 0);
        mem_gnt = 1;
        repeat (20) @(negedge clk);
        ep_req[6] = 0;
        chk(mem_req == 0, "R7 no request after abort", mem_req, 0);
        rd_chk(12'h254, 0, "R7 control cleared");
        rd_chk(12'h25C, 0, "R7 count cleared");
        rd_chk(12'h200, 0, "R7 no status after abort");

        // R4/R10: ch6, 12 bytes, burst type 2, irq disabled
        wr(12'h268, 32'h7000); wr(12'h26C, 12);
        ep_req[7] = 1;
        wr(12'h264, 32'h477);
        wait_done(6);
        ep_req[7] = 0;
        rd_chk(12'h268, 32'h700C, "R3 short transfer address");
        rd_chk(12'h264, 32'h476, "R4 enable clear, irq disabled");

        // R13/R5: zero-length starts, write-1-to-clear
        wr(12'h27C, 0);
        wr(12'h274, 32'h89);
        wr(12'h20C, 0);
        wr(12'h204, 32'h09);
        repeat (3) @(negedge clk);
        wr(12'h200, 32'h80);
        rd_chk(12'h200, 32'h01, "R13 zero length, R5 write-1 clears one bit");
        rd_chk(12'h200, 32'h00, "R5 cleared after read");

        // R1: count width
        wr(12'h27C, 32'h100000);
        rd_chk(12'h27C, 32'h100000, "R1 count holds 0x100000");
        wr(12'h27C, 32'hFFFFFFFF);
        rd_chk(12'h27C, 32'h1FFFFF, "R1 count is 21 bits");
        wr(12'h27C, 0);

        repeat (5) @(negedge clk);
        report();
    end

endmodule